// File: doc/BRIEF.md
# Serial Memory Target Engine

This block is the protocol engine of a 2 KiB byte-addressed memory that answers as a target on a two-wire I2C bus. SCL and SDA enter raw; the block passes them through two-flop synchronizers and finds clock edges, START and STOP on the system clock. It then shifts bytes in and out MSB first and reports acknowledge by pulling SDA low through an open-drain enable.

The first byte after a START is a control byte. It holds a fixed type code, three block-select bits that form the top of the 11-bit memory address, and a direction bit. A write then takes a word-address byte that fills the low 8 address bits, followed by data bytes. Reads return bytes from an internal pointer until the host declines to acknowledge. The storage is an inferred synchronous RAM inside the block. A write-protect input and a busy flag from the external write sequencer limit what the block accepts. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, sda_oe is low, so the block is not pulling SDA.
- R2: A control byte with bits 7:4 equal to 1010 is acknowledged: SDA is held low through the ninth SCL high period. Bits 3:1 become address bits 10:8. Bit 0 selects the direction, with 1 meaning read.
- R3: A control byte whose bits 7:4 differ from 1010 is not acknowledged. Every byte after it is ignored until the next START or STOP.
- R4: In a write, the byte after the control byte loads address bits 7:0. Each following data byte is acknowledged and stored at the pointer.
- R5: After each stored byte, only address bits 4:0 increment, so the pointer wraps inside its 32-byte page (for example 0x53F goes to 0x520).
- R6: In a read, all 11 address bits increment after each byte sent, and the pointer wraps from 0x7FF to 0x000.
- R7: A random read sets the pointer by a write of the control and address bytes, then a repeated START and a read control byte. A read control byte sent directly reads from the block-select bits joined with the existing low 8 pointer bits.
- R8: While wp is high, the control and address bytes are acknowledged, but a data byte is not acknowledged and memory keeps its content.
- R9: While wr_busy is high, a control byte gets no acknowledge.
- R10: When the host does not acknowledge a data byte, the block releases SDA and stays released until STOP or START.
- R11: sda_oe changes only while the synchronized SCL is low. An acknowledge is released after the SCL falling edge that ends it.
- R12: A START at any point releases SDA and makes the next byte a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL from the pad |
| sda_in | input | 1 | Raw SDA from the pad, as seen on the bus |
| wp | input | 1 | Write protect; high refuses data bytes |
| wr_busy | input | 1 | High while the write sequencer runs a cycle |
| sda_oe | output | 1 | High pulls SDA low (open drain) |

## Verification
The hardest situation to reach is one where two address rules meet in a single transfer. A write that runs past the page end wraps to the page start, and a later read across that same boundary must carry into the next page. The stimulus first stores a byte in the following page. It then writes three bytes starting two below the page end, and reads three bytes back from the start address. The only way the third byte read can be the byte from the following page is if writes wrapped and reads carried. The 0x7FF-to-0x000 read wrap, followed by a current-address read that reuses the pointer it leaves behind, is reached the same way.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

  localparam int          BYTE_W       = 8;
  localparam logic [3:0]  DEV_TYPE     = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_raw;
          sda_pipe <= sda_raw;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_mem_ram.sv
module i2c_mem_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wp,
  input  logic              wr_busy,
  output logic              sda_oe,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam int BLK_W  = ADDR_W - BYTE_W;
  localparam int TYPE_W = BYTE_W - 1 - BLK_W;

  tgt_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-2:0] tx_sh;
  logic [ADDR_W-1:0] ptr;
  logic              rd_dir;
  logic              host_ack;
  logic              byte_done;
  logic              type_ok;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign type_ok   = (rx_sh[BYTE_W-1 -: TYPE_W] == DEV_TYPE[3 -: TYPE_W]);
  assign mem_raddr = ptr;
  assign mem_re    = (state == ST_CTRL_ACK) || (state == ST_RACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      rd_dir    <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_evt) begin
        state  <= ST_CTRL;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_CTRL) begin
                if (type_ok && !wr_busy) begin
                  ptr[ADDR_W-1 -: BLK_W] <= rx_sh[BLK_W:1];
                  rd_dir <= rx_sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_CTRL_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                ptr[BYTE_W-1:0] <= rx_sh;
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                if (!wp) begin
                  mem_we    <= 1'b1;
                  mem_waddr <= ptr;
                  mem_wdata <= rx_sh;
                  ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_WDATA_ACK;
                end else begin
                  state     <= ST_IDLE;
                end
              end
            end
          end
          ST_CTRL_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_dir) begin
                tx_sh  <= mem_rdata[BYTE_W-2:0];
                sda_oe <= ~mem_rdata[BYTE_W-1];
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_ADDR;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                state  <= ST_RACK;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-3:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                bitcnt <= '0;
                tx_sh  <= mem_rdata[BYTE_W-2:0];
                sda_oe <= ~mem_rdata[BYTE_W-1];
                state  <= ST_RDATA;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp,
  input  logic wr_busy,
  output logic sda_oe
);
  localparam int DATA_W = i2c_mem_pkg::BYTE_W;

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              mem_re;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_mem_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .wp(wp), .wr_busy(wr_busy), .sda_oe(sda_oe), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  i2c_mem_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_evt,
  input logic              sda_oe,
  input logic              wp,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  logic [ADDR_W-1:0] last_wa;
  logic              have_last;

  always_ff @(posedge clk) begin
    if (rst || start_evt) begin
      have_last <= 1'b0;
      last_wa   <= '0;
    end else if (mem_we) begin
      have_last <= 1'b1;
      last_wa   <= mem_waddr;
    end
  end

  // R11: the open-drain enable moves only while SCL is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R12: a START lets go of SDA
  a_r12_start_release: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe);

  // R8: no store while write protect was high
  a_r8_no_write_protected: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(wp));

  // R4: one store per data byte, never two cycles in a row
  a_r4_store_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R5: successive stores of a transfer stay in the page and step the low bits
  a_r5_page_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && have_last) |->
      (mem_waddr[ADDR_W-1:PAGE_W] == last_wa[ADDR_W-1:PAGE_W]) &&
      (mem_waddr[PAGE_W-1:0] == last_wa[PAGE_W-1:0] + 1'b1));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_evt(start_evt),
  .sda_oe(sda_oe), .wp(wp), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/1ps
module i2c_mem_target_test;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic wp = 1'b0;
  logic wr_busy = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic oe_prev = 1'b0;
  bit   done = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0] ref_mem   [2048];
  bit         ref_valid [2048];
  int         ref_ptr = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_oe ? 1'b0 : sda_drv;

  i2c_mem_target uut (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_bus),
    .wp(wp), .wr_busy(wr_busy), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11: per-clock reference comparison of the open-drain enable against SCL
  always @(posedge clk) begin
    #1;
    if (!rst && (sda_oe !== oe_prev))
      check(scl_drv == 1'b0, "R11 oe moved while SCL high", int'(scl_drv), 0);
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    tick(Q); sda_drv = b; tick(Q); scl_drv = 1'b1; tick(2*Q); scl_drv = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    tick(Q); sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    b = sda_bus; tick(Q); scl_drv = 1'b0;
  endtask

  task automatic bus_start();
    tick(Q); sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q); scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_drv = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!give_ack);
  endtask

  task automatic do_write(input logic [2:0] blk, input logic [7:0] word,
                          input logic [7:0] data [$]);
    bit ack;
    bus_start();
    put_byte({4'b1010, blk, 1'b0}, ack);
    check(ack == !wr_busy, wr_busy ? "R9 busy control byte" : "R2 control ack",
          int'(ack), int'(!wr_busy));
    if (!ack) begin bus_stop(); return; end
    put_byte(word, ack);
    check(ack, "R4 word address ack", int'(ack), 1);
    ref_ptr = {blk, word};
    foreach (data[k]) begin
      put_byte(data[k], ack);
      check(ack == !wp, wp ? "R8 protected data nack" : "R4 data ack",
            int'(ack), int'(!wp));
      if (wp) break;
      ref_mem[ref_ptr] = data[k];
      ref_valid[ref_ptr] = 1'b1;
      ref_ptr = {ref_ptr[10:5], 5'(ref_ptr[4:0] + 1)};
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [2:0] blk, input bit set_addr,
                         input logic [7:0] word, input int n, input string req);
    bit ack;
    logic [7:0] d;
    if (set_addr) begin
      bus_start();
      put_byte({4'b1010, blk, 1'b0}, ack);
      check(ack, "R7 random read control ack", int'(ack), 1);
      put_byte(word, ack);
      check(ack, "R7 random read address ack", int'(ack), 1);
      ref_ptr = {blk, word};
    end else begin
      ref_ptr = {blk, ref_ptr[7:0]};
    end
    bus_start();
    put_byte({4'b1010, blk, 1'b1}, ack);
    check(ack == !wr_busy, "R12 read control ack after START", int'(ack), int'(!wr_busy));
    if (!ack) begin bus_stop(); return; end
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      if (ref_valid[ref_ptr])
        check(d == ref_mem[ref_ptr], req, int'(d), int'(ref_mem[ref_ptr]));
      ref_ptr = (ref_ptr + 1) % 2048;
    end
    tick(Q);
    check(sda_oe == 1'b0, "R10 released after host nack", int'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] q [$];
    tick(5);
    check(sda_oe == 1'b0, "R1 reset oe", int'(sda_oe), 0);
    rst = 1'b0;
    tick(5);
    check(sda_oe == 1'b0, "R1 idle oe", int'(sda_oe), 0);

    // R4 / R7: plain write then random read
    q = '{8'hA5, 8'h3C, 8'h7E};
    do_write(3'd2, 8'h10, q);
    do_read(3'd2, 1'b1, 8'h10, 3, "R4 stored data");

    // R5 / R6: write wraps in page, read carries into next page
    q = '{8'h99};
    do_write(3'd5, 8'h40, q);
    q = '{8'h11, 8'h22, 8'h33};
    do_write(3'd5, 8'h3E, q);
    do_read(3'd5, 1'b1, 8'h3E, 3, "R6 read crosses page");
    do_read(3'd5, 1'b1, 8'h20, 1, "R5 page wrap write");

    // R6 / R7: top-of-memory wrap then current-address read
    q = '{8'hC3};
    do_write(3'd7, 8'hFF, q);
    q = '{8'h5A, 8'h66};
    do_write(3'd0, 8'h00, q);
    do_read(3'd7, 1'b1, 8'hFF, 2, "R6 wrap 7FF to 000");
    do_read(3'd0, 1'b0, 8'h00, 1, "R7 current address read");

    // R8: write protect
    wp = 1'b1;
    q = '{8'hFF};
    do_write(3'd2, 8'h10, q);
    wp = 1'b0;
    do_read(3'd2, 1'b1, 8'h10, 1, "R8 memory unchanged");

    // R9: busy
    wr_busy = 1'b1;
    q = '{8'h00};
    do_write(3'd2, 8'h11, q);
    wr_busy = 1'b0;
    do_read(3'd2, 1'b1, 8'h11, 1, "R9 memory unchanged after busy");

    // R3: wrong type code, later bytes ignored
    bus_start();
    put_byte(8'h90, ack);
    check(!ack, "R3 wrong type nack", int'(ack), 0);
    put_byte(8'h12, ack);
    check(!ack, "R3 following byte ignored", int'(ack), 0);
    put_byte(8'hEE, ack);
    check(!ack, "R3 data ignored", int'(ack), 0);
    bus_stop();
    do_read(3'd2, 1'b1, 8'h12, 1, "R3 memory unchanged");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule